// File: doc/BRIEF.md
# Self-Correcting Six-State Sequence Counter

This block is a 3-bit synchronous counter whose flip-flops behave as JK cells. Their J and K inputs come from a small set of fixed equations, and these produce a non-binary cycle of six codes. The codes 011 and 111 are never part of that cycle. If the register ever holds one of them, for example after an upset or a preload, the next clock returns it to the cycle. The output bits are named A (bit 2, the MSB), B (bit 1) and C (bit 0, the LSB).

The counter advances on every clock edge and has no enable. A synchronous active-low reset forces the code 000. A preload path writes any 3-bit code, including the two unused ones, on the next edge. The preload exists so that a bench or a debug controller can put the register into a chosen state and watch it recover.

Top module: `seq6_counter`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `state_q` is 000 after that edge. This holds whatever `preload_en` is.
- R2: With `rst_n` high and `preload_en` low, each edge moves `state_q` one step along the ring 000, 001, 010, 100, 101, 110, and 110 returns to 000.
- R3: With `rst_n` high and `preload_en` low, the unused code 011 becomes 100 after one edge.
- R4: With `rst_n` high and `preload_en` low, the unused code 111 becomes 000 after one edge.
- R5: When `rst_n` is high and `preload_en` is high at an edge, `state_q` equals the `preload_state` sampled at that edge. This takes precedence over counting and applies to all eight codes.
- R6: When `rst_n` is high and `preload_en` is low and `state_q` holds one of the six ring codes, the next edge never produces 011 or 111.
- R7: Each bit is updated as a JK cell: J=K=0 holds, J=0 K=1 clears, J=1 K=0 sets, J=K=1 toggles. The inputs are JA=KA=B, JB=C with KB=1, and JC=NOT B with KC=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low, forces 000 |
| preload_en | input | 1 | Write `preload_state` into the register on this edge |
| preload_state | input | 3 | Code to write when `preload_en` is high |
| state_q | output | 3 | Counter state, bit 2 = A, bit 1 = B, bit 0 = C |

## Verification
A wrong J or K term in any bit shows up at `state_q` on the very next edge, because every bit is visible at the port and there is no hidden state. A fault in the self-correction path can only be seen from the two unused codes. Each of those codes is therefore preloaded and its successor compared one edge later. A bit whose cell misreads its JK pair (for example, hold taken as toggle) moves the ring off its order within at most six edges. For this reason the free run covers more than one full lap.

// File: rtl/seq6_pkg.sv
// Package: shared width, bit positions and JK input pair type for the
// six-state counter. Assumes a 3-bit state with A as the MSB.
package seq6_pkg;
    localparam int unsigned SEQ_W = 3;
    localparam int unsigned IDX_A = SEQ_W - 1;
    localparam int unsigned IDX_B = SEQ_W - 2;
    localparam int unsigned IDX_C = SEQ_W - 3;

    typedef logic [SEQ_W-1:0] seq_state_t;

    typedef struct packed {
        logic j;
        logic k;
    } jk_in_t;

    typedef jk_in_t [SEQ_W-1:0] jk_vec_t;
endpackage

// File: rtl/seq6_jk_cell.sv
// Module: one JK-behaving storage bit with synchronous active-low reset and a
// synchronous load. Assumes reset outranks load, and load outranks JK.
module seq6_jk_cell
    import seq6_pkg::*;
#(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_en,
    input  logic   load_val,
    input  jk_in_t jk,
    output logic   q
);
    // Update the bit: reset, then load, then the JK action table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (load_en) begin
            q <= load_val;
        end else begin
            case ({jk.j, jk.k})
                2'b00:   q <= q;
                2'b01:   q <= 1'b0;
                2'b10:   q <= 1'b1;
                default: q <= ~q;
            endcase
        end
    end
endmodule

// File: rtl/seq6_jk_eqn.sv
// Module: combinational J/K input equations for the six-state ring.
// Assumes the state vector is ordered A (MSB), B, C (LSB).
module seq6_jk_eqn
    import seq6_pkg::*;
(
    input  seq_state_t cur,
    output jk_vec_t    jk
);
    // Build each bit's J and K from the present state.
    always_comb begin
        jk[IDX_A].j = cur[IDX_B];
        jk[IDX_A].k = cur[IDX_B];
        jk[IDX_B].j = cur[IDX_C];
        jk[IDX_B].k = 1'b1;
        jk[IDX_C].j = ~cur[IDX_B];
        jk[IDX_C].k = 1'b1;
    end
endmodule

// File: rtl/seq6_counter.sv
// Module: top of the self-correcting six-state counter. One JK cell per bit,
// driven by the shared equation block. Assumes a single clock domain and that
// preload_state is stable around the edge where preload_en is high.
module seq6_counter
    import seq6_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preload_en,
    input  logic [SEQ_W-1:0] preload_state,
    output logic [SEQ_W-1:0] state_q
);
    jk_vec_t    jk_w;
    seq_state_t cur_w;

    // Present state fed back to the equations.
    assign cur_w = state_q;

    seq6_jk_eqn u_eqn (
        .cur (cur_w),
        .jk  (jk_w)
    );

    for (genvar gi = 0; gi < SEQ_W; gi++) begin : g_bit
        seq6_jk_cell #(
            .RESET_VAL (1'b0)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (preload_en),
            .load_val (preload_state[gi]),
            .jk       (jk_w[gi]),
            .q        (state_q[gi])
        );
    end
endmodule

// File: rtl/seq6_counter_chk.sv
// Module: property checker for seq6_counter, attached by bind. Watches only
// the ports; the successor table below is the specified ring, not the design.
module seq6_counter_chk
    import seq6_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             preload_en,
    input logic [SEQ_W-1:0] preload_state,
    input logic [SEQ_W-1:0] state_q
);
    logic primed = 1'b0;
    logic rst_n_d;

    function automatic logic [SEQ_W-1:0] ring_succ(input logic [SEQ_W-1:0] s);
        case (s)
            3'b000:  return 3'b001;
            3'b001:  return 3'b010;
            3'b010:  return 3'b100;
            3'b100:  return 3'b101;
            3'b101:  return 3'b110;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic is_spare(input logic [SEQ_W-1:0] s);
        return (s == 3'b011) || (s == 3'b111);
    endfunction

    // Remember reset from the previous edge for the R1 immediate check.
    always_ff @(posedge clk) begin
        primed  <= 1'b1;
        rst_n_d <= rst_n;
        if (primed && !rst_n_d) begin
            a_r1_reset_clears : assert (state_q == '0)
                else $error("R1 reset did not clear state");
        end
    end

    a_r2_ring_order : assert property (@(posedge clk) disable iff (!rst_n)
        (!preload_en && !is_spare(state_q)) |=> (state_q == ring_succ($past(state_q))));

    a_r3_spare_low_recovers : assert property (@(posedge clk) disable iff (!rst_n)
        (!preload_en && state_q == 3'b011) |=> (state_q == 3'b100));

    a_r4_spare_high_recovers : assert property (@(posedge clk) disable iff (!rst_n)
        (!preload_en && state_q == 3'b111) |=> (state_q == 3'b000));

    a_r5_preload_wins : assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |=> (state_q == $past(preload_state)));

    a_r6_never_enters_spare : assert property (@(posedge clk) disable iff (!rst_n)
        (!preload_en && !is_spare(state_q)) |=> !is_spare(state_q));
endmodule

bind seq6_counter seq6_counter_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .preload_en    (preload_en),
    .preload_state (preload_state),
    .state_q       (state_q)
);

// File: tb/seq6_counter_tb_top.sv
// Bench: behavioural reference (ring held in a queue) compared every clock.
module seq6_counter_tb_top;
    localparam int HALF_NS = 2;
    localparam int WATCHDOG_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       preload_en = 1'b0;
    logic [2:0] preload_state = 3'b000;
    logic [2:0] state_q;

    int n_vec  = 0;
    int n_fail = 0;
    int model  = 0;
    int ring[$] = '{0, 1, 2, 4, 5, 6};

    seq6_counter dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .preload_en    (preload_en),
        .preload_state (preload_state),
        .state_q       (state_q)
    );

    always #(HALF_NS) clk = ~clk;

    // Reference successor: next ring entry, spare codes per R3 and R4.
    function automatic int ref_next(input int s);
        if (s == 3) return 4;
        if (s == 7) return 0;
        for (int i = 0; i < ring.size(); i++)
            if (ring[i] == s) return ring[(i + 1) % ring.size()];
        return -1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one edge's inputs, update the model, compare after the edge.
    task automatic step(input logic rn, input logic pe, input int pv);
        string tag;
        @(negedge clk);
        rst_n         = rn;
        preload_en    = pe;
        preload_state = pv[2:0];
        if (!rn) begin
            tag = "R1"; model = 0;
        end else if (pe) begin
            tag = "R5"; model = pv;
        end else begin
            if (model == 3)      tag = "R3";
            else if (model == 7) tag = "R4";
            else                 tag = "R2";
            model = ref_next(model);
        end
        @(posedge clk);
        #1;
        check(tag, int'(state_q), model);
        if (tag == "R2")  // R6: ring code never leads to a spare code
            check("R6", int'(state_q == 3'b011 || state_q == 3'b111), 0);
    endtask

    initial begin
        #(WATCHDOG_CYC * 2 * HALF_NS);
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        step(1'b0, 1'b0, 0);                 // R1 reset state
        step(1'b0, 1'b1, 5);                 // R1 reset outranks preload
        for (int i = 0; i < 14; i++) step(1'b1, 1'b0, 0);  // R2, R7 free run
        for (int s = 0; s < 8; s++) begin    // R5 preload each code, then run
            step(1'b1, 1'b1, s);
            for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0);
        end
        step(1'b1, 1'b1, 3);                 // R3 spare low
        step(1'b1, 1'b0, 0);
        step(1'b1, 1'b1, 7);                 // R4 spare high
        step(1'b1, 1'b0, 0);
        step(1'b1, 1'b1, 7);                 // R4 then reset mid-run
        step(1'b0, 1'b0, 0);
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 0);
        step(1'b1, 1'b1, 2);                 // R5 back-to-back preloads
        step(1'b1, 1'b1, 6);
        step(1'b1, 1'b0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule